// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Compare Interrupt

This block is a 32-bit periodic timer reached through a small synchronous register port. It has five word registers: control, status, load value, compare value and a read-only live count. A down-counter steps once per prescaled tick. The tick comes from one of three clock sources, or from none. When the count reaches zero, the counter either reloads from the load register or wraps to the all-ones value.

Each time a tick brings the counter onto the compare value, a sticky status flag is set. The flag drives a single interrupt line, which is gated by a compare-interrupt enable and by the run bit. Software clears the flag by writing a one to it.

Writing the control register with the soft-reset bit set returns the block to a near-reset state. It keeps the run bit, the restart-mode bit and the four stored low-power mode bits. Setting the run bit with restart mode selected restarts the count. Load writes can optionally overwrite the live count at once.

A two-state machine (ST_HALT, ST_RUN) tracks whether ticks may flow. The transition RUN_GO (ST_HALT to ST_RUN) is taken when the next control value has the run bit set and a nonzero clock source. The transition RUN_STOP (ST_RUN to ST_HALT) is taken when either of those conditions goes away. The counter and the prescaler advance only in ST_RUN.

Top module: `ptmr_top`

## Requirements
- R1: Word addresses 0 (control), 1 (status), 2 (load), 3 (compare) and 4 (count, read-only) are decoded. Every other address reads zero and ignores writes. Read data appears registered one cycle after a selected access. When nothing is selected, read data is zero.
- R2: A control write stores bits [25:0] and reads back with bits [31:26] as zero. The control fields are:
  - bit 0: run
  - bit 1: restart-on-run
  - bit 2: compare interrupt enable
  - bit 3: reload-from-load
  - bit 4: soft reset
  - bit 5: immediate overwrite
  - bits 9:6: stored low-power enables
  - bits 11:10: clock source
  - bits 23:12: prescale
  - bits 25:24: spare
- R3: The clock source selects the tick pulse: 00 none (counter held), 01 every clock cycle, 10 the fast-pulse input, 11 the slow-pulse input. The counter decrements once every (prescale+1) selected pulses.
- R4: A tick at count zero loads the load register when reload-from-load is 1, and loads 0xFFFFFFFF when it is 0.
- R5: A control write that takes run from 0 to 1 with restart-on-run set loads the counter with the load value (reload-from-load=1) or 0xFFFFFFFF (=0). With restart-on-run clear, the count resumes from its held value.
- R6: With immediate overwrite set, a load write also loads the counter with the written value in the same cycle. Otherwise the counter is untouched.
- R7: The status flag (status bit 0) is set when a tick moves the counter onto the compare value.
- R8: Writing status with bit 0 at 1 clears the flag, unless a compare hit happens in the same cycle. Writing 0 leaves it unchanged.
- R9: The interrupt output is high exactly when the flag, the compare interrupt enable and run are all set.
- R10: A soft-reset control write stores only the run, restart-on-run and low-power bits of the written value. It also clears the flag and sets both the load register and the counter to 0xFFFFFFFF.
- R11: With run clear, the counter holds and no compare hit occurs.
- R12: Every control write restarts the prescaler from zero and suppresses the tick in that cycle.
- R13: After hard reset, control, status and compare are zero, and load and count are 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| fast_pulse | input | 1 | Single-cycle pulses of the high-frequency source |
| slow_pulse | input | 1 | Single-cycle pulses of the slow source |
| irq | output | 1 | Compare interrupt |

## Verification
A wrong count value, or a wrong prescaler phase, shows up at the ports on the next count read. It also shifts the cycle in which the interrupt rises, so the mismatch is visible within a few ticks. A wrong flag or wrong control state corrupts the interrupt line in the very next cycle, and it is also visible in the next status or control read. Random register traffic with small load, compare and prescale values forces frequent wraps, reloads, hits and soft resets. Every cycle's interrupt and every read are compared against a bench model written from the requirements.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
    localparam int CTRL_W   = 26;
    localparam int PSW      = 12;
    localparam int B_RUN    = 0;
    localparam int B_RSTRT  = 1;
    localparam int B_CIE    = 2;
    localparam int B_RELOAD = 3;
    localparam int B_SRST   = 4;
    localparam int B_OVW    = 5;
    localparam int SRC_LO   = 10;
    localparam int PRE_LO   = 12;
    localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h00003C3;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_STAT = 3'd1,
        A_LOAD = 3'd2,
        A_CMP  = 3'd3,
        A_CNT  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_FAST = 2'd2,
        SRC_SLOW = 2'd3
    } src_e;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              cmp_hit,
    input  logic [DW-1:0]     cnt_val,
    output logic [DW-1:0]     rdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CTRL_W-1:0] ctrl_d,
    output logic [DW-1:0]     load_q,
    output logic [DW-1:0]     cmp_q,
    output logic              flag_q,
    output logic              ctrl_wr,
    output logic              soft_rst,
    output logic              start_req,
    output logic              ovw_req
);
    localparam logic [AW-1:0] ADR_CTRL = AW'(A_CTRL);
    localparam logic [AW-1:0] ADR_STAT = AW'(A_STAT);
    localparam logic [AW-1:0] ADR_LOAD = AW'(A_LOAD);
    localparam logic [AW-1:0] ADR_CMP  = AW'(A_CMP);
    localparam logic [AW-1:0] ADR_CNT  = AW'(A_CNT);

    logic wr, stat_wr, load_wr, cmp_wr;
    logic [DW-1:0] rd_mux;

    assign wr      = sel && we;
    assign ctrl_wr = wr && (addr == ADR_CTRL);
    assign stat_wr = wr && (addr == ADR_STAT);
    assign load_wr = wr && (addr == ADR_LOAD);
    assign cmp_wr  = wr && (addr == ADR_CMP);

    assign soft_rst  = ctrl_wr && wdata[B_SRST];
    assign start_req = ctrl_wr && !soft_rst && wdata[B_RUN]
                       && !ctrl_q[B_RUN] && wdata[B_RSTRT];
    assign ovw_req   = load_wr && ctrl_q[B_OVW];

    always_comb begin
        if (!ctrl_wr)
            ctrl_d = ctrl_q;
        else if (soft_rst)
            ctrl_d = wdata[CTRL_W-1:0] & KEEP_MASK;
        else
            ctrl_d = wdata[CTRL_W-1:0];
    end

    always_comb begin
        unique case (addr)
            ADR_CTRL: rd_mux = DW'(ctrl_q);
            ADR_STAT: rd_mux = DW'(flag_q);
            ADR_LOAD: rd_mux = load_q;
            ADR_CMP:  rd_mux = cmp_q;
            ADR_CNT:  rd_mux = cnt_val;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '1;
            cmp_q  <= '0;
            flag_q <= 1'b0;
            rdata  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            rdata  <= sel ? rd_mux : '0;
            if (soft_rst)
                load_q <= '1;
            else if (load_wr)
                load_q <= wdata;
            if (cmp_wr)
                cmp_q <= wdata;
            if (soft_rst)
                flag_q <= 1'b0;
            else if (cmp_hit)
                flag_q <= 1'b1;
            else if (stat_wr && wdata[0])
                flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ptmr_presc.sv
module ptmr_presc
    import ptmr_pkg::*;
#(
    parameter int PW = PSW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          running,
    input  logic [1:0]    src,
    input  logic          fast_pulse,
    input  logic          slow_pulse,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] pcnt_q;
    logic pulse, at_end;

    always_comb begin
        unique case (src_e'(src))
            SRC_OFF:  pulse = 1'b0;
            SRC_MAIN: pulse = 1'b1;
            SRC_FAST: pulse = fast_pulse;
            SRC_SLOW: pulse = slow_pulse;
            default:  pulse = 1'b0;
        endcase
    end

    assign at_end = (pcnt_q == div);
    assign tick   = running && pulse && at_end && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (restart)
            pcnt_q <= '0;
        else if (running && pulse)
            pcnt_q <= at_end ? '0 : pcnt_q + 1'b1;
    end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count
    import ptmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_next,
    input  logic          tick,
    input  logic          reload_sel,
    input  logic          start_reload_sel,
    input  logic [DW-1:0] load_q,
    input  logic [DW-1:0] cmp_q,
    input  logic          soft_rst,
    input  logic          start_req,
    input  logic          ovw_req,
    input  logic [DW-1:0] ovw_val,
    output logic          running,
    output logic          cnt_force,
    output logic          cmp_hit,
    output logic [DW-1:0] cnt_q
);
    run_st_e st_q, st_d;
    logic [DW-1:0] dec_val;

    always_comb begin
        unique case (st_q)
            ST_HALT: st_d = go_next ? ST_RUN : ST_HALT;
            ST_RUN:  st_d = go_next ? ST_RUN : ST_HALT;
            default: st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_HALT;
        else
            st_q <= st_d;
    end

    assign running   = (st_q == ST_RUN);
    assign cnt_force = soft_rst || start_req || ovw_req;
    assign dec_val   = (cnt_q == '0) ? (reload_sel ? load_q : '1)
                                     : cnt_q - 1'b1;
    assign cmp_hit   = tick && !cnt_force && (dec_val == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '1;
        else if (soft_rst)
            cnt_q <= '1;
        else if (start_req)
            cnt_q <= start_reload_sel ? load_q : '1;
        else if (ovw_req)
            cnt_q <= ovw_val;
        else if (tick)
            cnt_q <= dec_val;
    end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          fast_pulse,
    input  logic          slow_pulse,
    output logic          irq
);
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [DW-1:0] load_q, cmp_q, cnt_q;
    logic flag_q, ctrl_wr, soft_rst, start_req, ovw_req;
    logic running, tick, cnt_force, cmp_hit, go_next;

    assign go_next = ctrl_d[B_RUN] && (ctrl_d[SRC_LO +: 2] != 2'b00);

    ptmr_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
        .addr(bus_addr), .wdata(bus_wdata), .cmp_hit(cmp_hit),
        .cnt_val(cnt_q), .rdata(bus_rdata), .ctrl_q(ctrl_q),
        .ctrl_d(ctrl_d), .load_q(load_q), .cmp_q(cmp_q),
        .flag_q(flag_q), .ctrl_wr(ctrl_wr), .soft_rst(soft_rst),
        .start_req(start_req), .ovw_req(ovw_req)
    );

    ptmr_presc #(.PW(PSW)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .running(running),
        .src(ctrl_q[SRC_LO +: 2]), .fast_pulse(fast_pulse),
        .slow_pulse(slow_pulse), .div(ctrl_q[PRE_LO +: PSW]), .tick(tick)
    );

    ptmr_count #(.DW(DW)) u_count (
        .clk(clk), .rst_n(rst_n), .go_next(go_next), .tick(tick),
        .reload_sel(ctrl_q[B_RELOAD]),
        .start_reload_sel(bus_wdata[B_RELOAD]),
        .load_q(load_q), .cmp_q(cmp_q), .soft_rst(soft_rst),
        .start_req(start_req), .ovw_req(ovw_req), .ovw_val(bus_wdata),
        .running(running), .cnt_force(cnt_force), .cmp_hit(cmp_hit),
        .cnt_q(cnt_q)
    );

    assign irq = flag_q && ctrl_q[B_CIE] && ctrl_q[B_RUN];
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] bus_rdata,
    input logic          tick,
    input logic          run_bit,
    input logic          reload_bit,
    input logic          cnt_force,
    input logic          cmp_hit,
    input logic          flag_q,
    input logic [DW-1:0] load_q,
    input logic [DW-1:0] cnt_q
);
    logic srst_wr, clr_wr, ctrl_acc;
    assign srst_wr  = bus_sel && bus_we && (bus_addr == AW'(0)) && bus_wdata[4];
    assign clr_wr   = bus_sel && bus_we && (bus_addr == AW'(1)) && bus_wdata[0];
    assign ctrl_acc = bus_sel && (bus_addr == AW'(0));

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_bit && !cnt_force) |=> $stable(cnt_q)); // R11
    AST_WRAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_force && !reload_bit && cnt_q == '0) |=> (cnt_q == '1)); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !cmp_hit) |=> !flag_q); // R8
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        srst_wr |=> (cnt_q == '1 && load_q == '1 && !flag_q)); // R10
    AST_CTRL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_acc |=> (bus_rdata[DW-1:26] == '0)); // R2
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> flag_q); // R7
endmodule

bind ptmr_top ptmr_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .run_bit(ctrl_q[0]), .reload_bit(ctrl_q[3]),
    .cnt_force(cnt_force), .cmp_hit(cmp_hit), .flag_q(flag_q),
    .load_q(load_q), .cnt_q(cnt_q)
);

// File: tb/tb_ptmr_top.sv
`timescale 1ns/1ps
module tb_ptmr_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic fast_pulse = 1'b0, slow_pulse = 1'b0;
    logic irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    logic [25:0] m_ctrl;
    logic        m_flag;
    logic [31:0] m_load, m_cmp, m_cnt;
    logic [11:0] m_p;

    ptmr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_pulse(fast_pulse), .slow_pulse(slow_pulse), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: m_read = {6'b0, m_ctrl};
            3'd1: m_read = {31'b0, m_flag};
            3'd2: m_read = m_load;
            3'd3: m_read = m_cmp;
            3'd4: m_read = m_cnt;
            default: m_read = 32'h0;
        endcase
    endfunction

    function automatic string def_tag(input logic [2:0] a);
        case (a)
            3'd0: def_tag = "R2";
            3'd1: def_tag = "R7";
            3'd2: def_tag = "R6";
            3'd4: def_tag = "R3";
            default: def_tag = "R1";
        endcase
    endfunction

    task automatic m_reset();
        m_ctrl = '0; m_flag = 0; m_load = '1; m_cmp = '0; m_cnt = '1; m_p = '0;
    endtask

    // one clock: drive at negedge, predict, check after the edge
    task automatic step(input bit s, input bit w, input logic [2:0] a,
                        input logic [31:0] d, input string tag);
        logic [25:0] n_ctrl; logic n_flag; logic [31:0] n_load, n_cmp, n_cnt;
        logic [11:0] n_p; logic [31:0] exp_rd, dec;
        bit cw, sw, lw, mw, srst, start, ovw, run, pulse, tk, hit, frc;
        bit fp, sp;
        fp = ($urandom % 3) == 0; sp = ($urandom % 7) == 0;
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        fast_pulse = fp; slow_pulse = sp;
        cw = s && w && a == 0; sw = s && w && a == 1;
        lw = s && w && a == 2; mw = s && w && a == 3;
        srst  = cw && d[4];
        start = cw && !srst && d[0] && !m_ctrl[0] && d[1];
        ovw   = lw && m_ctrl[5];
        frc   = srst || start || ovw;
        run   = m_ctrl[0] && m_ctrl[11:10] != 2'b00;
        case (m_ctrl[11:10])
            2'b01: pulse = 1;
            2'b10: pulse = fp;
            2'b11: pulse = sp;
            default: pulse = 0;
        endcase
        tk = run && pulse && (m_p == m_ctrl[23:12]) && !cw;
        n_p = cw ? 12'd0 : (run && pulse) ? ((m_p == m_ctrl[23:12]) ? 12'd0 : m_p + 1) : m_p;
        n_ctrl = cw ? (srst ? (d[25:0] & 26'h3C3) : d[25:0]) : m_ctrl;
        n_load = srst ? 32'hFFFF_FFFF : lw ? d : m_load;
        n_cmp  = mw ? d : m_cmp;
        dec = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
        hit = tk && !frc && dec == m_cmp;
        if (srst) n_cnt = 32'hFFFF_FFFF;
        else if (start) n_cnt = d[3] ? m_load : 32'hFFFF_FFFF;
        else if (ovw) n_cnt = d;
        else if (tk) n_cnt = dec;
        else n_cnt = m_cnt;
        n_flag = srst ? 1'b0 : hit ? 1'b1 : (sw && d[0]) ? 1'b0 : m_flag;
        exp_rd = s ? m_read(a) : 32'h0;
        @(posedge clk); #1;
        m_ctrl = n_ctrl; m_flag = n_flag; m_load = n_load; m_cmp = n_cmp;
        m_cnt = n_cnt; m_p = n_p;
        if (s && !w)
            chk(bus_rdata === exp_rd, (tag == "") ? def_tag(a) : tag, bus_rdata, exp_rd);
        chk(irq === (m_flag && m_ctrl[2] && m_ctrl[0]), "R9", {31'b0, irq},
            {31'b0, m_flag && m_ctrl[2] && m_ctrl[0]});
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1, 0, a, 32'h0, tag);
    endtask
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1, 1, a, d, "");
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 32'h0, "");
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset values, R1 undecoded reads
        rd(3'd0, "R13"); rd(3'd1, "R13"); rd(3'd2, "R13");
        rd(3'd3, "R13"); rd(3'd4, "R13"); rd(3'd6, "R1");
        // R1 write to undecoded address has no effect
        wr(3'd7, 32'h1234_5678); rd(3'd5, "R1"); rd(3'd2, "R1");
        // R2 upper bits dropped
        wr(3'd0, 32'hFC00_0040); rd(3'd0, "R2");
        // R5/R7/R9: load 5, compare 2, restart with reload, main source
        wr(3'd2, 32'd5); wr(3'd3, 32'd2);
        wr(3'd0, 32'h0000_040F); rd(3'd4, "R5");
        idle(2); rd(3'd1, "R7");
        // R8 clear flag
        wr(3'd1, 32'h0); rd(3'd1, "R8");
        wr(3'd1, 32'h1); rd(3'd1, "R8");
        idle(4); rd(3'd4, "R4");
        // R11 disable freezes
        wr(3'd0, 32'h0000_040E); rd(3'd4, "R11"); idle(5); rd(3'd4, "R11");
        // R5 resume without restart mode
        wr(3'd0, 32'h0000_040D); idle(2); rd(3'd4, "R5");
        // R6 overwrite, then R4 wrap with reload clear
        wr(3'd0, 32'h0000_0421); wr(3'd2, 32'd1); rd(3'd4, "R6");
        idle(3); rd(3'd4, "R4");
        // R3/R12 prescale of 3 on main source
        wr(3'd0, 32'h0000_3421); wr(3'd2, 32'd100);
        idle(9); rd(3'd4, "R3");
        wr(3'd0, 32'h0000_3421); idle(2); rd(3'd4, "R12");
        // R3 source off holds
        wr(3'd0, 32'h0000_0021); idle(4); rd(3'd4, "R3");
        // R10 soft reset keeps run/restart/low-power bits
        wr(3'd0, 32'h03FF_FFFF); rd(3'd0, "R10"); rd(3'd2, "R10");
        rd(3'd4, "R10"); rd(3'd1, "R10");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [31:0] d;
            r = $urandom % 10;
            d = $urandom;
            case (r)
                0: begin
                    d[23:12] = 12'($urandom % 3);
                    if (($urandom % 8) != 0) d[4] = 1'b0;
                    if (($urandom % 3) != 0) d[0] = 1'b1;
                    wr(3'd0, d);
                end
                1: wr(3'd1, d);
                2: wr(3'd2, 32'($urandom % 24));
                3: wr(3'd3, 32'($urandom % 24));
                4, 5: rd(3'($urandom % 8), "");
                6: rd(3'd4, "R3");
                default: idle(1);
            endcase
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule